// File: doc/BRIEF.md
# UART Interrupt and DMA Request Controller

This block turns the state of a buffered UART into interrupt and DMA request outputs. It watches the occupancy counts of the transmit and receive FIFOs, the busy flag of the transmit shift register, the receive-character strobe with its error flags, and a baud-rate tick. It combines these with programmable thresholds, an idle timeout length and the enable bits.

The block keeps two kinds of status flag. Receive errors and the receive idle timeout are sticky flags that software clears by writing ones. The threshold and transmit-done flags follow the FIFO levels live. A single registered interrupt line is the OR of every enabled flag. Two DMA request lines tell a DMA engine when the transmit FIFO needs refilling and when the receive FIFO holds a full batch.

Top module: `uart_irq_dma_ctrl`

## Requirements
- R1: Each receive error flag is set in the cycle after an `rx_push` strobe that carries the matching error bit. The flags sit at status bit 0 (overrun), bit 1 (parity), bit 2 (framing) and bit 3 (break). A set flag stays set until it is cleared.
- R2: A one written to bit i of `clr_w1c` clears sticky status bit i on the next clock edge and leaves the other bits unchanged. If the same bit is set and cleared in one cycle, the set wins.
- R3: The idle timeout flag (status bit 4) is set after `tmo_len` baud ticks pass with the receive FIFO not empty and no `rx_push` or `rx_pop`. Either strobe restarts the count. A `tmo_len` of zero disables the timeout.
- R4: While the receive FIFO is empty, the timeout count is held at zero and the timeout flag is never set.
- R5: The timeout fires only once per idle period. It can fire again only after a new character has been pushed.
- R6: Status bit 5 is high whenever `tx_level < tx_thresh`.
- R7: Status bit 6 is high only when `tx_level` is zero and `tx_shift_busy` is low.
- R8: Status bit 7 is high whenever `rx_level >= rx_thresh`.
- R9: `tx_dma_req` is high only when `tx_dma_en` is set and `tx_level < tx_thresh`.
- R10: `rx_dma_req` is high only when `rx_dma_en` is set and `rx_level == rx_thresh`.
- R11: `irq` is a register. It goes high one cycle after any status bit is set together with its `irq_en` bit, and it stays low when no enabled flag is set.
- R12: After reset, all sticky flags and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| tx_shift_busy | input | 1 | Transmit shift register still shifting |
| rx_push | input | 1 | A received character enters the FIFO |
| rx_pop | input | 1 | The receive FIFO is read |
| rx_err_overrun | input | 1 | Overrun with this character |
| rx_err_parity | input | 1 | Parity error with this character |
| rx_err_frame | input | 1 | Framing error with this character |
| rx_err_break | input | 1 | Break detected with this character |
| baud_tick | input | 1 | One pulse per bit time |
| tx_thresh | input | CNT_W | Transmit threshold |
| rx_thresh | input | CNT_W | Receive threshold |
| tmo_len | input | TMO_W | Idle timeout in bit times |
| irq_en | input | 8 | Per-flag interrupt enables |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| clr_w1c | input | 5 | Write-one-to-clear strobes for the sticky flags |
| status | output | 8 | Flag vector |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench targets the off-by-one edges of the comparisons:
- A threshold of zero, a full FIFO, and a level one below or one above the threshold. A strict-versus-inclusive mix-up would raise a DMA request too early or never raise it.
- A character that arrives part way through an idle count. A design that fails to restart the count would report a timeout early.
- A long idle stretch after a timeout has been cleared. A timeout that re-arms would fire again and again on a stalled line.
- A set and a clear on the same flag in one cycle. A design that gives the clear priority would lose an error.
- The interrupt in the cycle its enable is written. This exposes a combinational interrupt path.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int NFLAG   = 8;
   localparam int NSTICKY = 5;
   localparam int F_OVR   = 0;
   localparam int F_PAR   = 1;
   localparam int F_FRM   = 2;
   localparam int F_BRK   = 3;
   localparam int F_TMO   = 4;
   localparam int F_TXT   = 5;
   localparam int F_TXD   = 6;
   localparam int F_RXT   = 7;
endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[i]) flag_q <= 1'b1;
            else if (clr_i[i]) flag_q <= 1'b0;
         end
         assign flag_o[i] = flag_q;

         p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q);
         p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !clr_i[i]) |=> flag_q);
         p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_q);
      end
   endgenerate
endmodule

// File: rtl/uirq_rx_idle.sv
module uirq_rx_idle #(
   parameter int CNT_W = 5,
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [TMO_W-1:0] tmo_len,
   output logic             hit_o
);
   localparam logic [TMO_W-1:0] CNT_MAX = '1;

   logic [TMO_W-1:0] cnt_q;
   logic             fired_q;
   logic             rx_empty, restart, last_bit;

   assign rx_empty = (rx_level == '0);
   assign restart  = rx_push | rx_pop;
   assign last_bit = (tmo_len != '0) && (cnt_q == TMO_W'(tmo_len - 1'b1));
   assign hit_o    = baud_tick & ~rx_empty & ~restart & ~fired_q & last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cnt_q <= '0;
      else if (rx_empty || restart || hit_o)        cnt_q <= '0;
      else if (baud_tick && !fired_q && cnt_q != CNT_MAX)
                                                    cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fired_q <= 1'b0;
      else if (rx_push) fired_q <= 1'b0;
      else if (hit_o)   fired_q <= 1'b1;
   end

   p_zero_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |=> (cnt_q == '0));
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> (cnt_q == '0));
   p_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);
endmodule

// File: rtl/uirq_level_cmp.sv
module uirq_level_cmp #(
   parameter int CNT_W   = 5,
   parameter bit DMA_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tx_level,
   input  logic [CNT_W-1:0] tx_thresh,
   input  logic             tx_busy,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [CNT_W-1:0] rx_thresh,
   input  logic             tx_dma_en,
   input  logic             rx_dma_en,
   output logic             tx_below_o,
   output logic             tx_done_o,
   output logic             rx_reached_o,
   output logic             tx_dma_o,
   output logic             rx_dma_o
);
   logic tx_dma_d, rx_dma_d;

   assign tx_below_o   = tx_level < tx_thresh;
   assign tx_done_o    = (tx_level == '0) & ~tx_busy;
   assign rx_reached_o = rx_level >= rx_thresh;
   assign tx_dma_d     = tx_dma_en & tx_below_o;
   assign rx_dma_d     = rx_dma_en & (rx_level == rx_thresh);

   generate
      if (DMA_REG) begin : g_dma_reg
         logic tx_q, rx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_q <= 1'b0;
               rx_q <= 1'b0;
            end else begin
               tx_q <= tx_dma_d;
               rx_q <= rx_dma_d;
            end
         end
         assign tx_dma_o = tx_q;
         assign rx_dma_o = rx_q;
         p_txdma_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_dma_en |=> !tx_dma_o);
         p_rxdma_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_dma_en |=> !rx_dma_o);
      end else begin : g_dma_comb
         assign tx_dma_o = tx_dma_d;
         assign rx_dma_o = rx_dma_d;
         p_txdma_lvl_r9: assert property (@(posedge clk) disable iff (!rst_n)
            tx_dma_o |-> (tx_dma_en && tx_below_o));
         p_rxdma_lvl_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rx_dma_o |-> (rx_dma_en && rx_reached_o));
      end
   endgenerate
endmodule

// File: rtl/uart_irq_dma_ctrl.sv
module uart_irq_dma_ctrl
   import uirq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int TMO_W      = 8,
   parameter bit DMA_REG    = 1'b0,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   tx_level,
   input  logic [CNT_W-1:0]   rx_level,
   input  logic               tx_shift_busy,
   input  logic               rx_push,
   input  logic               rx_pop,
   input  logic               rx_err_overrun,
   input  logic               rx_err_parity,
   input  logic               rx_err_frame,
   input  logic               rx_err_break,
   input  logic               baud_tick,
   input  logic [CNT_W-1:0]   tx_thresh,
   input  logic [CNT_W-1:0]   rx_thresh,
   input  logic [TMO_W-1:0]   tmo_len,
   input  logic [NFLAG-1:0]   irq_en,
   input  logic               tx_dma_en,
   input  logic               rx_dma_en,
   input  logic [NSTICKY-1:0] clr_w1c,
   output logic [NFLAG-1:0]   status,
   output logic               irq,
   output logic               tx_dma_req,
   output logic               rx_dma_req
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("TMO_W must be at least 2");
      end
   endgenerate

   logic [NSTICKY-1:0] sticky_set, sticky_q;
   logic               tmo_hit, tx_below, tx_done, rx_reached, irq_q;

   uirq_rx_idle #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_idle (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_push(rx_push),
      .rx_pop(rx_pop), .rx_level(rx_level), .tmo_len(tmo_len), .hit_o(tmo_hit)
   );

   always_comb begin
      sticky_set        = '0;
      sticky_set[F_OVR] = rx_push & rx_err_overrun;
      sticky_set[F_PAR] = rx_push & rx_err_parity;
      sticky_set[F_FRM] = rx_push & rx_err_frame;
      sticky_set[F_BRK] = rx_push & rx_err_break;
      sticky_set[F_TMO] = tmo_hit;
   end

   uirq_sticky #(.N(NSTICKY)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_i(sticky_set), .clr_i(clr_w1c),
      .flag_o(sticky_q)
   );

   uirq_level_cmp #(.CNT_W(CNT_W), .DMA_REG(DMA_REG)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_thresh(tx_thresh),
      .tx_busy(tx_shift_busy), .rx_level(rx_level), .rx_thresh(rx_thresh),
      .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .tx_below_o(tx_below),
      .tx_done_o(tx_done), .rx_reached_o(rx_reached), .tx_dma_o(tx_dma_req),
      .rx_dma_o(rx_dma_req)
   );

   assign status = {rx_reached, tx_done, tx_below, sticky_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status & irq_en);
   end
   assign irq = irq_q;

   p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sticky_q & irq_en[NSTICKY-1:0])) |=> irq);
   p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |=> !irq);
endmodule

// File: tb/uart_irq_dma_ctrl_bench.sv
module uart_irq_dma_ctrl_bench;
   localparam int CW = 5;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [CW-1:0] tx_level = '0, rx_level = '0, tx_thresh = '0, rx_thresh = '0;
   logic          tx_shift_busy = 0, rx_push = 0, rx_pop = 0, baud_tick = 0;
   logic          e_ovr = 0, e_par = 0, e_frm = 0, e_brk = 0;
   logic [7:0]    tmo_len = '0, irq_en = '0;
   logic          tx_dma_en = 0, rx_dma_en = 0;
   logic [4:0]    clr_w1c = '0;
   logic [7:0]    status;
   logic          irq, tx_dma_req, rx_dma_req;

   int checks = 0, fails = 0, cyc = 0;

   always #5 clk = ~clk;

   uart_irq_dma_ctrl u_uart_irq_dma_ctrl (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
      .tx_shift_busy(tx_shift_busy), .rx_push(rx_push), .rx_pop(rx_pop),
      .rx_err_overrun(e_ovr), .rx_err_parity(e_par), .rx_err_frame(e_frm),
      .rx_err_break(e_brk), .baud_tick(baud_tick), .tx_thresh(tx_thresh),
      .rx_thresh(rx_thresh), .tmo_len(tmo_len), .irq_en(irq_en),
      .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .clr_w1c(clr_w1c),
      .status(status), .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog: act=%0d exp<20000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic push(logic [3:0] err);
      @(negedge clk);
      rx_push = 1; {e_brk, e_frm, e_par, e_ovr} = err;
      @(negedge clk);
      rx_push = 0; {e_brk, e_frm, e_par, e_ovr} = '0;
   endtask

   task automatic clear(logic [4:0] m);
      @(negedge clk); clr_w1c = m;
      @(negedge clk); clr_w1c = '0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); baud_tick = 1;
         @(negedge clk); baud_tick = 0;
      end
   endtask

   // {txl, txt, busy, rxl, rxt, txen, rxen, exp txb, txd, rxt, txdma, rxdma}
   localparam logic [27:0] VEC [0:7] = '{
      {5'd0,  5'd4,  1'b0, 5'd0,  5'd4,  1'b1, 1'b1, 5'b11010},
      {5'd0,  5'd4,  1'b1, 5'd4,  5'd4,  1'b1, 1'b1, 5'b10111},
      {5'd4,  5'd4,  1'b0, 5'd5,  5'd4,  1'b1, 1'b1, 5'b00100},
      {5'd3,  5'd4,  1'b0, 5'd3,  5'd4,  1'b0, 1'b0, 5'b10000},
      {5'd16, 5'd16, 1'b1, 5'd16, 5'd16, 1'b1, 1'b1, 5'b00101},
      {5'd0,  5'd0,  1'b0, 5'd2,  5'd0,  1'b1, 1'b1, 5'b01100},
      {5'd15, 5'd16, 1'b0, 5'd15, 5'd16, 1'b1, 1'b1, 5'b10010},
      {5'd1,  5'd2,  1'b0, 5'd1,  5'd1,  1'b1, 1'b0, 5'b10110}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 sticky", status[4:0], 0);
      chk("R12 irq", irq, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R12 after release", status[4:0], 0);

      // R6 R7 R8 R9 R10 vector table
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         {tx_level, tx_thresh, tx_shift_busy, rx_level, rx_thresh,
          tx_dma_en, rx_dma_en} = VEC[v][27:5];
         #1;
         chk("R6 tx below", status[5], VEC[v][4]);
         chk("R7 tx done", status[6], VEC[v][3]);
         chk("R8 rx reached", status[7], VEC[v][2]);
         chk("R9 tx dma", tx_dma_req, VEC[v][1]);
         chk("R10 rx dma", rx_dma_req, VEC[v][0]);
      end

      // R1 sticky errors
      rx_level = 3; tmo_len = 0;
      push(4'b0010);
      chk("R1 parity set", status[4:0], 5'b00010);
      repeat (5) @(negedge clk);
      chk("R1 parity held", status[4:0], 5'b00010);
      push(4'b1001);
      chk("R1 break+overrun", status[4:0], 5'b01011);

      // R2 W1C clears only written bits; set wins
      clear(5'b00011);
      chk("R2 partial clear", status[4:0], 5'b01000);
      @(negedge clk);
      rx_push = 1; e_frm = 1; clr_w1c = 5'b00100;
      @(negedge clk);
      rx_push = 0; e_frm = 0; clr_w1c = 0;
      chk("R2 set wins", status[4:0], 5'b01100);
      clear(5'b11111);
      chk("R2 all clear", status[4:0], 0);

      // R3 timeout with restart
      tmo_len = 4;
      push(4'b0000);
      ticks(3);
      chk("R3 early", status[4], 0);
      push(4'b0000);
      ticks(3);
      chk("R3 restarted", status[4], 0);
      ticks(1);
      chk("R3 fired", status[4], 1);

      // R5 once per idle period
      clear(5'b10000);
      ticks(10);
      chk("R5 no refire", status[4], 0);
      @(negedge clk); rx_pop = 1;
      @(negedge clk); rx_pop = 0;
      ticks(6);
      chk("R5 pop no rearm", status[4], 0);
      push(4'b0000);
      ticks(4);
      chk("R5 rearm on char", status[4], 1);

      // R11 registered combined interrupt
      @(negedge clk); irq_en = 8'h10;
      #1;
      chk("R11 irq lags", irq, 0);
      @(negedge clk);
      chk("R11 irq high", irq, 1);
      irq_en = 8'h01;
      @(negedge clk); @(negedge clk);
      chk("R11 masked", irq, 0);
      irq_en = 0;

      // R4 empty FIFO holds timeout
      clear(5'b10000);
      push(4'b0000);
      rx_level = 0;
      ticks(10);
      chk("R4 empty no timeout", status[4], 0);
      rx_level = 2;
      ticks(3);
      chk("R4 count from zero", status[4], 0);
      ticks(1);
      chk("R4 fires after refill", status[4], 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule